// File: doc/BRIEF.md
# Move Destination Decoder and Register Writer

This block carries out the write half of a register-to-register move in a small 16-bit accumulator machine. It receives a 7-bit destination code, the source value and a flag that marks the source as one byte wide. It decodes the code into a target, which is either one register of the core or a data-memory location reached through a pointer. It then commits the write on the next clock edge. Indirect targets produce a one-cycle data-memory write request, and any pointer pre-step happens on that same edge.

A move that targets one of the prefix registers arms a one-shot prefix. The prefix affects only the next move. It switches a few codes to a second bank: the upper eight accumulators, three further control bytes, and the general register's high byte. It also supplies prefix register 0 as the high byte when a byte source is widened to a word. A combinational read port looks up any register by the same code and prefix bit, so the neighbouring source stage, or a bench, can see the stored state.

Top module: `mov_dst_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register and pointer is cleared to zero and the prefix is disarmed. `mem_we` is high only during a cycle with `mv_valid` high.
- R2: Code 7'h76 is a null target. A move to it changes no register and raises no memory write.
- R3: Code {n[2:0],4'h9} writes accumulator n without the prefix and accumulator 8+n with the prefix. A move writes no other accumulator.
- R4: Code 7'h0A writes the accumulator indexed by the low four bits of the accumulator-pointer byte.
- R5: Code 7'h0D adds one to the stack pointer (mod 2^16). In the same cycle it writes a full word (`mem_byte`=0) at the new stack address.
- R6: Codes {n,2'b00,4'hF}, {n,2'b01,4'hF} and {n,2'b10,4'hF} write memory through data pointer n. The pointer is left alone, pre-incremented or pre-decremented (mod 2^16), and the write uses the updated pointer. Code {n,2'b11,4'hF} loads data pointer n.
- R7: Codes 7'h0E, 7'h1E and 7'h2E write memory at base + zero-extended offset (mod 2^16). The 8-bit offset is kept, pre-incremented or pre-decremented (mod 2^8), and the address uses the updated offset. 7'h3E loads the offset and 7'h7E loads the base.
- R8: Code 7'h5E writes the whole general register and 7'h6E writes only its low byte. With the prefix armed, 7'h1E writes only its high byte.
- R9: The control bytes are selected as follows. Without the prefix: 7'h08 accumulator pointer, 7'h18 accumulator control, 7'h48 status, 7'h58 interrupt control, 7'h68 interrupt mask. With the prefix: 7'h08 system control, 7'h68 clock control, 7'h78 watchdog control. Any other xxx 1000 code has no effect.
- R10: A byte source written to a 16-bit target gets high byte 00h, or prefix register 0 when the prefix is armed. A word source written to a byte target keeps its low byte. Pointer-indirect writes set `mem_byte` equal to `src_byte`.
- R11: Code {n,4'hB} loads prefix register n and arms the prefix. The prefix stays armed through idle cycles and clears after the next move, whatever that move targets.
- R12: Code 7'h1D loads the stack pointer, 7'h2D the interrupt vector, {3'b11n,4'hD} loop counter n, and 7'h4E the data-pointer control word.
- R13: Codes with no assigned target (for example 7'h00, 7'h1A, 7'h3D, 7'h78 without the prefix) change nothing and raise no write.
- R14: `rd_data` returns the register that `rd_code`/`rd_pfx` would select for a write. Byte registers are zero-extended, 7'h0A returns the active accumulator, and memory and null codes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_valid | input | 1 | A move writes in this cycle |
| dst_code | input | 7 | Destination code |
| src_data | input | 16 | Source value |
| src_byte | input | 1 | Source is 8 bits wide |
| rd_pfx | input | 1 | Prefix bit for the read lookup |
| rd_code | input | 7 | Code for the read lookup |
| rd_data | output | 16 | Register selected by the lookup |
| mem_we | output | 1 | Data-memory write request |
| mem_addr | output | 16 | Data-memory write address |
| mem_wdata | output | 16 | Data-memory write data |
| mem_byte | output | 1 | Write only the low byte |

## Verification
A wrong pointer or offset shows on `mem_addr` during the next indirect move through that pointer. The read port shows it one cycle after the faulty edge. A prefix that is not cleared, or is cleared too early, shows up at the next move. The symptom is the wrong bank on the read port, or a wrong high byte on `mem_wdata` or in a widened register. Writes that land on the wrong accumulator or control byte appear on the read port in the cycle after the edge, because the model compares every register after each move.

// File: rtl/mvd_pkg.sv
`timescale 1ns/1ps
// Shared widths and decoded-target types for the move destination unit.
// Assumes a 16-bit word, 8-bit byte and 7-bit destination code.
package mvd_pkg;
    localparam int unsigned DW = 16;
    localparam int unsigned BW = 8;
    localparam int unsigned CW = 7;
    localparam int unsigned XW = 4;

    typedef enum logic [4:0] {
        K_NONE, K_NULL, K_ACC, K_ACT, K_CTL, K_PFX, K_SP, K_IV, K_LC,
        K_PUSH, K_DPMEM, K_DPINC, K_DPDEC, K_DP,
        K_BPMEM, K_BPINC, K_BPDEC, K_OFFS, K_DPC, K_GR, K_GRL, K_GRH, K_BP
    } kind_e;

    typedef struct packed {
        kind_e         kind;
        logic [XW-1:0] idx;
    } dst_t;
endpackage

// File: rtl/mvd_decode.sv
`timescale 1ns/1ps
// Pure decoder: maps a destination code and the prefix state to a target
// class and an index. Assumes nothing about timing; purely combinational.
module mvd_decode
    import mvd_pkg::*;
(
    input  logic [CW-1:0] code,
    input  logic          pfx,
    output dst_t          dst
);
    logic [3:0] lo;
    logic [2:0] hi;
    assign lo = code[3:0];
    assign hi = code[6:4];

    // Classify the code by its low nibble, then refine by the high bits
    always_comb begin
        dst.kind = K_NONE;
        dst.idx  = '0;
        case (lo)
            4'h6: if (hi == 3'd7) dst.kind = K_NULL;
            4'h8: begin
                if (pfx) begin
                    case (hi)
                        3'd0: begin dst.kind = K_CTL; dst.idx = 4'd5; end
                        3'd6: begin dst.kind = K_CTL; dst.idx = 4'd6; end
                        3'd7: begin dst.kind = K_CTL; dst.idx = 4'd7; end
                        default: ;
                    endcase
                end else begin
                    case (hi)
                        3'd0: begin dst.kind = K_CTL; dst.idx = 4'd0; end
                        3'd1: begin dst.kind = K_CTL; dst.idx = 4'd1; end
                        3'd4: begin dst.kind = K_CTL; dst.idx = 4'd2; end
                        3'd5: begin dst.kind = K_CTL; dst.idx = 4'd3; end
                        3'd6: begin dst.kind = K_CTL; dst.idx = 4'd4; end
                        default: ;
                    endcase
                end
            end
            4'h9: begin dst.kind = K_ACC; dst.idx = {pfx, hi}; end
            4'hA: if (hi == 3'd0) dst.kind = K_ACT;
            4'hB: begin dst.kind = K_PFX; dst.idx = {1'b0, hi}; end
            4'hD: begin
                case (hi)
                    3'd0: dst.kind = K_PUSH;
                    3'd1: dst.kind = K_SP;
                    3'd2: dst.kind = K_IV;
                    3'd6, 3'd7: begin dst.kind = K_LC; dst.idx = {3'b000, hi[0]}; end
                    default: ;
                endcase
            end
            4'hE: begin
                if (pfx && hi == 3'd1) dst.kind = K_GRH;
                else begin
                    case (hi)
                        3'd0: dst.kind = K_BPMEM;
                        3'd1: dst.kind = K_BPINC;
                        3'd2: dst.kind = K_BPDEC;
                        3'd3: dst.kind = K_OFFS;
                        3'd4: dst.kind = K_DPC;
                        3'd5: dst.kind = K_GR;
                        3'd6: dst.kind = K_GRL;
                        default: dst.kind = K_BP;
                    endcase
                end
            end
            4'hF: begin
                dst.idx = {3'b000, hi[2]};
                case (hi[1:0])
                    2'd0: dst.kind = K_DPMEM;
                    2'd1: dst.kind = K_DPINC;
                    2'd2: dst.kind = K_DPDEC;
                    default: dst.kind = K_DP;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mvd_accfile.sv
`timescale 1ns/1ps
// Accumulator file: N word registers, one write port and one async read port.
// Assumes the caller already qualified the write enable with a valid move.
module mvd_accfile #(
    parameter  int unsigned N  = 16,
    parameter  int unsigned W  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [N-1:0][W-1:0] regs_v;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [W-1:0] ent_q;
        // Load this entry when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n)                          ent_q <= '0;
            else if (we && widx == IW'(g))       ent_q <= wdata;
        end
        assign regs_v[g] = ent_q;
    end

    assign rdata = regs_v[ridx];

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_v));
    // R3
    acc_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_v[$past(widx)] == $past(wdata));
endmodule

// File: rtl/mvd_ptrs.sv
`timescale 1ns/1ps
// Pointer unit: stack pointer, data pointers, base and offset, plus the
// address of an indirect write. The address uses the already-stepped value;
// pointer and memory write commit on the same edge.
module mvd_ptrs
    import mvd_pkg::*;
#(
    parameter  int unsigned DP_N = 2,
    localparam int unsigned DI   = (DP_N > 1) ? $clog2(DP_N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mv,
    input  kind_e                    kind,
    input  logic [DI-1:0]            dsel,
    input  logic [DW-1:0]            wword,
    input  logic [BW-1:0]            wbyte,
    output logic                     mem_hit,
    output logic [DW-1:0]            mem_addr,
    output logic [DW-1:0]            sp_o,
    output logic [DW-1:0]            bp_o,
    output logic [BW-1:0]            offs_o,
    output logic [DP_N-1:0][DW-1:0]  dp_o
);
    logic [DW-1:0]           sp_q, sp_n, bp_q, bp_n;
    logic [BW-1:0]           offs_q, offs_n;
    logic [DP_N-1:0][DW-1:0] dp_q, dp_n;

    // Next pointer values and the indirect write address
    always_comb begin
        sp_n = sp_q; bp_n = bp_q; offs_n = offs_q; dp_n = dp_q;
        mem_hit = 1'b0; mem_addr = '0;
        if (mv) begin
            case (kind)
                K_SP:    sp_n = wword;
                K_PUSH:  begin sp_n = sp_q + 1'b1; mem_hit = 1'b1; mem_addr = sp_n; end
                K_DP:    dp_n[dsel] = wword;
                K_DPMEM, K_DPINC, K_DPDEC: begin
                    if (kind == K_DPINC)      dp_n[dsel] = dp_q[dsel] + 1'b1;
                    else if (kind == K_DPDEC) dp_n[dsel] = dp_q[dsel] - 1'b1;
                    mem_hit  = 1'b1;
                    mem_addr = dp_n[dsel];
                end
                K_BP:    bp_n = wword;
                K_OFFS:  offs_n = wbyte;
                K_BPMEM, K_BPINC, K_BPDEC: begin
                    if (kind == K_BPINC)      offs_n = offs_q + 1'b1;
                    else if (kind == K_BPDEC) offs_n = offs_q - 1'b1;
                    mem_hit  = 1'b1;
                    mem_addr = bp_q + {{(DW-BW){1'b0}}, offs_n};
                end
                default: ;
            endcase
        end
    end

    // Register the pointer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0; bp_q <= '0; offs_q <= '0; dp_q <= '0;
        end else begin
            sp_q <= sp_n; bp_q <= bp_n; offs_q <= offs_n; dp_q <= dp_n;
        end
    end

    assign sp_o = sp_q;
    assign bp_o = bp_q;
    assign offs_o = offs_q;
    assign dp_o = dp_q;

    // R5
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv && kind == K_PUSH |=> sp_q == $past(mem_addr));
    // R6
    dp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv && (kind == K_DPMEM || kind == K_DPINC || kind == K_DPDEC)
        |=> dp_q[$past(dsel)] == $past(mem_addr));
    // R6
    dp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv && kind == K_DPMEM |=> $stable(dp_q));
    // R7
    bp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv && (kind == K_BPMEM || kind == K_BPINC || kind == K_BPDEC)
        |=> $past(mem_addr) == bp_q + {{(DW-BW){1'b0}}, offs_q});
    // R7
    offs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv && kind == K_BPMEM |=> $stable(offs_q));
endmodule

// File: rtl/mov_dst_unit.sv
`timescale 1ns/1ps
// Move destination unit: decodes a destination code, widens or narrows the
// source, writes the selected register or requests a memory write, and
// tracks the one-shot prefix. Assumes one move per valid cycle and that a
// prefix-register write by one move arms the prefix for the next move only.
module mov_dst_unit
    import mvd_pkg::*;
#(
    parameter int unsigned ACC_N = 16,
    parameter int unsigned PFX_N = 8,
    parameter int unsigned LC_N  = 2,
    parameter int unsigned DP_N  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mv_valid,
    input  logic [6:0]    dst_code,
    input  logic [15:0]   src_data,
    input  logic          src_byte,
    input  logic          rd_pfx,
    input  logic [6:0]    rd_code,
    output logic [15:0]   rd_data,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          mem_byte
);
    localparam int unsigned CTL_N = 8;
    localparam int unsigned AI = $clog2(ACC_N);
    localparam int unsigned PI = $clog2(PFX_N);
    localparam int unsigned LI = (LC_N > 1) ? $clog2(LC_N) : 1;
    localparam int unsigned DI = (DP_N > 1) ? $clog2(DP_N) : 1;

    dst_t wd, rdd;
    logic armed_q;
    logic [CTL_N-1:0][BW-1:0] ctl_q;
    logic [PFX_N-1:0][BW-1:0] pfx_q;
    logic [LC_N-1:0][DW-1:0]  lc_q;
    logic [DW-1:0] iv_q, dpc_q, gr_q, wide, acc_rdata, sp_w, bp_w;
    logic [BW-1:0] lob, offs_w;
    logic [DP_N-1:0][DW-1:0] dp_w;
    logic [AI-1:0] ap_idx, acc_widx, acc_ridx;
    logic acc_we, mem_hit;

    mvd_decode u_wdec (.code(dst_code), .pfx(armed_q), .dst(wd));
    mvd_decode u_rdec (.code(rd_code),  .pfx(rd_pfx),  .dst(rdd));

    // Source shaping: low byte for byte targets, widened word for word targets
    assign lob  = src_data[BW-1:0];
    assign wide = src_byte ? {(armed_q ? pfx_q[0] : {BW{1'b0}}), lob} : src_data;

    assign ap_idx   = ctl_q[0][AI-1:0];
    assign acc_we   = mv_valid && (wd.kind == K_ACC || wd.kind == K_ACT);
    assign acc_widx = (wd.kind == K_ACT) ? ap_idx : wd.idx[AI-1:0];
    assign acc_ridx = (rdd.kind == K_ACT) ? ap_idx : rdd.idx[AI-1:0];

    mvd_accfile #(.N(ACC_N), .W(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .we(acc_we), .widx(acc_widx), .wdata(wide),
        .ridx(acc_ridx), .rdata(acc_rdata)
    );

    mvd_ptrs #(.DP_N(DP_N)) u_ptr (
        .clk(clk), .rst_n(rst_n), .mv(mv_valid), .kind(wd.kind),
        .dsel(wd.idx[DI-1:0]), .wword(wide), .wbyte(lob),
        .mem_hit(mem_hit), .mem_addr(mem_addr), .sp_o(sp_w), .bp_o(bp_w),
        .offs_o(offs_w), .dp_o(dp_w)
    );

    assign mem_we    = mem_hit;
    assign mem_wdata = wide;
    assign mem_byte  = mem_hit && src_byte && (wd.kind != K_PUSH);

    // Direct register writes and the one-shot prefix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0; ctl_q <= '0; pfx_q <= '0; lc_q <= '0;
            iv_q <= '0; dpc_q <= '0; gr_q <= '0;
        end else if (mv_valid) begin
            armed_q <= (wd.kind == K_PFX);
            case (wd.kind)
                K_CTL: ctl_q[wd.idx[2:0]] <= lob;
                K_PFX: pfx_q[wd.idx[PI-1:0]] <= lob;
                K_IV:  iv_q <= wide;
                K_LC:  lc_q[wd.idx[LI-1:0]] <= wide;
                K_DPC: dpc_q <= wide;
                K_GR:  gr_q <= wide;
                K_GRL: gr_q[BW-1:0] <= lob;
                K_GRH: gr_q[DW-1:BW] <= lob;
                default: ;
            endcase
        end
    end

    // Read lookup by code and prefix bit
    always_comb begin
        rd_data = '0;
        case (rdd.kind)
            K_ACC, K_ACT: rd_data = acc_rdata;
            K_CTL:  rd_data = {{(DW-BW){1'b0}}, ctl_q[rdd.idx[2:0]]};
            K_PFX:  rd_data = {{(DW-BW){1'b0}}, pfx_q[rdd.idx[PI-1:0]]};
            K_SP:   rd_data = sp_w;
            K_IV:   rd_data = iv_q;
            K_LC:   rd_data = lc_q[rdd.idx[LI-1:0]];
            K_DP:   rd_data = dp_w[rdd.idx[DI-1:0]];
            K_OFFS: rd_data = {{(DW-BW){1'b0}}, offs_w};
            K_DPC:  rd_data = dpc_q;
            K_GR:   rd_data = gr_q;
            K_GRL:  rd_data = {{(DW-BW){1'b0}}, gr_q[BW-1:0]};
            K_GRH:  rd_data = {{(DW-BW){1'b0}}, gr_q[DW-1:BW]};
            K_BP:   rd_data = bp_w;
            default: ;
        endcase
    end

    // R11
    pfx_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && wd.kind != K_PFX |=> !armed_q);
    // R11
    pfx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_valid |=> $stable(armed_q));
    // R2
    null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && wd.kind == K_NULL |-> !mem_we);
    // R1
    idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_valid |-> !mem_we);
    // R2
    null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && wd.kind == K_NULL |=> $stable(gr_q) && $stable(ctl_q) && $stable(sp_w));
endmodule

// File: tb/mov_dst_unit_tb.sv
`timescale 1ns/1ps
module mov_dst_unit_tb;
    logic clk = 1'b0, rst_n = 1'b0, mv_valid = 1'b0, src_byte = 1'b0, rd_pfx = 1'b0;
    logic [6:0]  dst_code = '0, rd_code = '0;
    logic [15:0] src_data = '0;
    logic [15:0] rd_data, mem_addr, mem_wdata;
    logic mem_we, mem_byte;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_acc [16];
    logic [7:0]  m_ctl [8];
    logic [7:0]  m_pfx [8];
    logic [15:0] m_lc [2];
    logic [15:0] m_dp [2];
    logic [15:0] m_sp, m_iv, m_dpc, m_gr, m_bp;
    logic [7:0]  m_offs;
    logic        m_arm;

    always #2.5 clk = ~clk;

    mov_dst_unit u_dut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .dst_code(dst_code),
        .src_data(src_data), .src_byte(src_byte), .rd_pfx(rd_pfx), .rd_code(rd_code),
        .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_byte(mem_byte)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic p, input logic [6:0] c, input logic [15:0] exp);
        rd_pfx = p; rd_code = c;
        #0.1;
        chk(req, $sformatf("lookup pfx=%0b code=%h", p, c), rd_data, exp);
    endtask

    // Compare every register of the model with the lookup port
    task automatic sweep();
        for (int i = 0; i < 8; i++) chk_rd("R3", 1'b0, {i[2:0], 4'h9}, m_acc[i]);
        for (int i = 0; i < 8; i++) chk_rd("R3", 1'b1, {i[2:0], 4'h9}, m_acc[8+i]);
        chk_rd("R4", 1'b0, 7'h0A, m_acc[m_ctl[0][3:0]]);
        chk_rd("R9", 1'b0, 7'h08, {8'h00, m_ctl[0]});
        chk_rd("R9", 1'b0, 7'h18, {8'h00, m_ctl[1]});
        chk_rd("R9", 1'b0, 7'h48, {8'h00, m_ctl[2]});
        chk_rd("R9", 1'b0, 7'h58, {8'h00, m_ctl[3]});
        chk_rd("R9", 1'b0, 7'h68, {8'h00, m_ctl[4]});
        chk_rd("R9", 1'b1, 7'h08, {8'h00, m_ctl[5]});
        chk_rd("R9", 1'b1, 7'h68, {8'h00, m_ctl[6]});
        chk_rd("R9", 1'b1, 7'h78, {8'h00, m_ctl[7]});
        for (int i = 0; i < 8; i++) chk_rd("R11", 1'b0, {i[2:0], 4'hB}, {8'h00, m_pfx[i]});
        chk_rd("R12", 1'b0, 7'h1D, m_sp);
        chk_rd("R12", 1'b0, 7'h2D, m_iv);
        chk_rd("R12", 1'b0, 7'h6D, m_lc[0]);
        chk_rd("R12", 1'b0, 7'h7D, m_lc[1]);
        chk_rd("R12", 1'b0, 7'h4E, m_dpc);
        chk_rd("R7", 1'b0, 7'h3E, {8'h00, m_offs});
        chk_rd("R7", 1'b0, 7'h7E, m_bp);
        chk_rd("R6", 1'b0, 7'h3F, m_dp[0]);
        chk_rd("R6", 1'b0, 7'h7F, m_dp[1]);
        chk_rd("R8", 1'b0, 7'h5E, m_gr);
        chk_rd("R8", 1'b0, 7'h6E, {8'h00, m_gr[7:0]});
        chk_rd("R8", 1'b1, 7'h1E, {8'h00, m_gr[15:8]});
        chk_rd("R14", 1'b0, 7'h76, 16'h0000);
        chk_rd("R14", 1'b0, 7'h0D, 16'h0000);
        chk("R1", "idle write request", {15'd0, mem_we}, 16'd0);
    endtask

    // One move: update the model, compare the memory request, clock it in
    task automatic move(input logic [6:0] code, input logic [15:0] src, input logic b);
        logic [3:0] lo;
        logic [2:0] t;
        logic a, ew, eb;
        logic [7:0] lb;
        logic [15:0] wide, ea;
        int k;
        @(negedge clk);
        mv_valid = 1'b1; dst_code = code; src_data = src; src_byte = b;
        lo = code[3:0]; t = code[6:4]; a = m_arm; lb = src[7:0];
        wide = b ? {(a ? m_pfx[0] : 8'h00), lb} : src;
        ew = 1'b0; ea = 16'h0; eb = b;
        if (lo == 4'h9) m_acc[{a, t}] = wide;
        else if (code == 7'h0A) m_acc[m_ctl[0][3:0]] = wide;
        else if (lo == 4'h8) begin
            if (a) begin
                if (t == 3'd0) m_ctl[5] = lb;
                else if (t == 3'd6) m_ctl[6] = lb;
                else if (t == 3'd7) m_ctl[7] = lb;
            end else begin
                if (t == 3'd0) m_ctl[0] = lb;
                else if (t == 3'd1) m_ctl[1] = lb;
                else if (t == 3'd4) m_ctl[2] = lb;
                else if (t == 3'd5) m_ctl[3] = lb;
                else if (t == 3'd6) m_ctl[4] = lb;
            end
        end
        else if (lo == 4'hB) m_pfx[t] = lb;
        else if (lo == 4'hD) begin
            if (t == 3'd0) begin m_sp = m_sp + 16'd1; ew = 1'b1; ea = m_sp; eb = 1'b0; end
            else if (t == 3'd1) m_sp = wide;
            else if (t == 3'd2) m_iv = wide;
            else if (t >= 3'd6) m_lc[t[0]] = wide;
        end
        else if (lo == 4'hE) begin
            if (a && t == 3'd1) m_gr[15:8] = lb;
            else if (t <= 3'd2) begin
                if (t == 3'd1) m_offs = m_offs + 8'd1;
                if (t == 3'd2) m_offs = m_offs - 8'd1;
                ew = 1'b1; ea = m_bp + {8'h00, m_offs};
            end
            else if (t == 3'd3) m_offs = lb;
            else if (t == 3'd4) m_dpc = wide;
            else if (t == 3'd5) m_gr = wide;
            else if (t == 3'd6) m_gr[7:0] = lb;
            else m_bp = wide;
        end
        else if (lo == 4'hF) begin
            k = t[2];
            if (t[1:0] == 2'd3) m_dp[k] = wide;
            else begin
                if (t[1:0] == 2'd1) m_dp[k] = m_dp[k] + 16'd1;
                if (t[1:0] == 2'd2) m_dp[k] = m_dp[k] - 16'd1;
                ew = 1'b1; ea = m_dp[k];
            end
        end
        m_arm = (lo == 4'hB);
        #1;
        chk("R5", $sformatf("write request code %h", code), {15'd0, mem_we}, {15'd0, ew});
        if (ew) begin
            chk("R6", $sformatf("address code %h", code), mem_addr, ea);
            chk("R10", $sformatf("data code %h", code), mem_wdata, wide);
            chk("R10", $sformatf("byte flag code %h", code), {15'd0, mem_byte}, {15'd0, eb});
        end
        @(posedge clk);
        #0.5;
        mv_valid = 1'b0;
        sweep();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_acc[i] = '0;
        for (int i = 0; i < 8; i++) begin m_ctl[i] = '0; m_pfx[i] = '0; end
        for (int i = 0; i < 2; i++) begin m_lc[i] = '0; m_dp[i] = '0; end
        m_sp = '0; m_iv = '0; m_dpc = '0; m_gr = '0; m_bp = '0; m_offs = '0; m_arm = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        sweep();
        rst_n = 1'b1;
        @(negedge clk);
        sweep();
        // R3 accumulators, word and byte sources (R10)
        move(7'h29, 16'h1234, 1'b0);
        move(7'h59, 16'hABCD, 1'b1);
        move(7'h79, 16'hFFFF, 1'b0);
        // R11 prefix, R3 upper bank, R10 prefix high byte
        move(7'h0B, 16'h5577, 1'b0);
        move(7'h39, 16'h0012, 1'b1);
        move(7'h39, 16'h0034, 1'b1);
        // R11 prefix survives idle cycles; R8 high byte
        move(7'h3B, 16'h0005, 1'b1);
        repeat (3) @(negedge clk);
        move(7'h1E, 16'h00AA, 1'b1);
        // R8 full and low-byte writes
        move(7'h5E, 16'h1357, 1'b0);
        move(7'h6E, 16'hBEEF, 1'b0);
        // R9 control bytes and R4 active accumulator
        move(7'h08, 16'h0003, 1'b0);
        move(7'h0A, 16'h4444, 1'b0);
        move(7'h18, 16'h0011, 1'b1);
        move(7'h48, 16'h0022, 1'b1);
        move(7'h58, 16'h0033, 1'b1);
        move(7'h68, 16'hC044, 1'b0);
        move(7'h1B, 16'h0001, 1'b1);
        move(7'h08, 16'h0055, 1'b1);
        move(7'h1B, 16'h0002, 1'b1);
        move(7'h68, 16'h0066, 1'b1);
        move(7'h1B, 16'h0003, 1'b1);
        move(7'h78, 16'h0077, 1'b1);
        move(7'h1B, 16'h0004, 1'b1);
        move(7'h18, 16'h0088, 1'b1);
        // R13 unassigned codes
        move(7'h78, 16'h0099, 1'b1);
        move(7'h00, 16'h1111, 1'b0);
        move(7'h1A, 16'h2222, 1'b0);
        move(7'h3D, 16'h3333, 1'b0);
        // R4 pointer reaching the upper bank
        move(7'h08, 16'h001F, 1'b1);
        move(7'h0A, 16'h7070, 1'b0);
        // R5 stack push with wrap, byte source widened to a word
        move(7'h1D, 16'hFFFE, 1'b0);
        move(7'h0D, 16'h9999, 1'b0);
        move(7'h0D, 16'h00C3, 1'b1);
        move(7'h0B, 16'h00E1, 1'b1);
        move(7'h0D, 16'h0042, 1'b1);
        // R6 data pointers, all step modes, with wrap
        move(7'h3F, 16'hFFFF, 1'b0);
        move(7'h1F, 16'h0101, 1'b0);
        move(7'h2F, 16'h0202, 1'b0);
        move(7'h0F, 16'h0033, 1'b1);
        move(7'h7F, 16'h0000, 1'b0);
        move(7'h6F, 16'h0404, 1'b0);
        move(7'h5F, 16'h0505, 1'b0);
        move(7'h4F, 16'h0006, 1'b1);
        // R7 base plus offset with offset wrap
        move(7'h7E, 16'h1000, 1'b0);
        move(7'h3E, 16'h12FF, 1'b0);
        move(7'h1E, 16'h0707, 1'b0);
        move(7'h2E, 16'h0808, 1'b0);
        move(7'h0E, 16'h0009, 1'b1);
        move(7'h7E, 16'hFFF0, 1'b0);
        move(7'h3E, 16'h0020, 1'b1);
        move(7'h0E, 16'h000A, 1'b0);
        // R12 remaining word registers
        move(7'h6D, 16'hA5A5, 1'b0);
        move(7'h7D, 16'h005A, 1'b1);
        move(7'h2D, 16'h0F0F, 1'b0);
        move(7'h4E, 16'hF00D, 1'b0);
        // R2 null target, also with the prefix armed
        move(7'h76, 16'hDEAD, 1'b0);
        move(7'h0B, 16'h0010, 1'b1);
        move(7'h76, 16'hBEEF, 1'b1);
        move(7'h1E, 16'h0B0B, 1'b0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule